// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns a stream of 32-bit instruction words into one decoded instruction record. The first word of every instruction carries an 8-bit type code in its least significant byte and up to two 8-bit parameters in the bytes above it. The type code alone decides how many further 32-bit words (none, one or two) belong to the same instruction. The decoder accepts the header word, works out that count, collects the extension words that follow, and then presents the full record. The record holds register fields, the immediate operand, the memory address, the sign-extended branch offset, an ALU operation code, memory read/write intent and an illegal-instruction flag.

Words enter on a valid/ready stream and the record leaves on a second valid/ready stream. A word is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The decoder holds one record. While that record is waiting (`out_valid` high), `in_ready` stays low, so the upstream source must keep its word stable until it is accepted. The record stays unchanged until the consumer takes it with `out_ready`. Fetching words from memory and executing the instruction are not part of this block.

Top module: `instr_decoder`

## Requirements
- R1: For a finished record, `out_type` equals bits 7:0 of the header word, `out_rega` equals bits 15:8 and `out_regb` equals bits 23:16. In two-register forms `out_rega` is the destination and `out_regb` is the source.
- R2: `out_len` gives the number of extension words. It is 1 for types 01, 03, 06, 07, 10–16, 1A–1C and 60. It is 2 for type 05. It is 0 for every other type, including unknown types.
- R3: Extension words are taken one per accepted `in_valid` strobe, and idle cycles between them are allowed. `out_valid` rises on the edge that accepts the last word of the instruction and stays low before that edge.
- R4: While `out_valid` is high, `in_ready` is low and all record outputs hold steady. `out_valid` falls on the edge where `out_valid` and `out_ready` are both high, and `in_ready` returns high after that edge.
- R5: Operand routing works as follows. `out_imm` takes the first extension word for types 01, 06, 10–16, 1A–1C and 60. For type 05, `out_addr` takes the first extension word and `out_imm` takes the second. For types 03 and 07, `out_addr` takes the first extension word. For shift-by-constant types 1D and 1E, `out_imm` is bits 23:16 zero-extended. Every other case gives zero.
- R6: For jump types 50–56 and call type 70, `out_offset` is header bits 31:8 sign-extended to 32 bits. For all other types it is zero.
- R7: `out_alu` uses this encoding: 0 none, 1 add, 2 subtract, 3 multiply, 4 divide, 5 modulo, 6 power, 7 compare, 8 increment, 9 decrement, 10 and, 11 or, 12 xor, 13 shift left, 14 shift right, 15 not. Types 10–16 and 20–26 map in order to codes 1–7. Types 17 and 18 map to 8 and 9. Types 1A–1E and 2A–2E map to 10–14. Type 1F maps to 15.
- R8: `out_mem_rd` is set for types 03, 04, 62 and 71. `out_mem_wr` is set for types 05, 06, 07, 08, 60, 61, 70 and 72. The two flags are never both set.
- R9: A type code outside the defined set sets `out_illegal`. The defined set is 01–08, 10–18, 1A–1F, 20–26, 2A–2E, 50–56, 60–62, 70–72, EE and FF.
- R10: `out_illegal` is also set when a register field that the type uses holds 00 or a code above 06. Bits 15:8 are a register for types 01–04, 06–08, 10–1F, 20–26, 2A–2E, 61, 62 and 72. Bits 23:16 are a register for types 02, 04, 08, 20–26 and 2A–2E. The instruction still consumes its extension words.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Instruction word (header or extension) |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_type | output | 8 | Type code |
| out_rega | output | 8 | Parameter byte in bits 15:8 |
| out_regb | output | 8 | Parameter byte in bits 23:16 |
| out_len | output | 2 | Number of extension words |
| out_alu | output | 4 | ALU operation code |
| out_mem_rd | output | 1 | Instruction reads memory |
| out_mem_wr | output | 1 | Instruction writes memory |
| out_imm | output | 32 | Immediate operand |
| out_addr | output | 32 | Immediate memory address |
| out_offset | output | 32 | Sign-extended branch offset |
| out_illegal | output | 1 | Illegal type or register code |

## Verification
A remaining-word count that is wrong shows up on the instruction it concerns: `out_valid` rises one strobe early or late. Because the decoder then treats the next word as a header or as an extension, the following record is corrupted as well. A header or classification captured in the wrong cycle gives field values on the very next record that do not match the header word that was sent. A valid flag that fails to clear shows at once as `in_ready` staying low after the consumer handshake.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int EXT_MAX = 2;
  localparam int LEN_W   = $clog2(EXT_MAX + 1);

  typedef enum logic [3:0] {
    ALU_NONE = 4'd0,  ALU_ADD = 4'd1,  ALU_SUB = 4'd2,  ALU_MUL = 4'd3,
    ALU_DIV  = 4'd4,  ALU_MOD = 4'd5,  ALU_POW = 4'd6,  ALU_CMP = 4'd7,
    ALU_INC  = 4'd8,  ALU_DEC = 4'd9,  ALU_AND = 4'd10, ALU_OR  = 4'd11,
    ALU_XOR  = 4'd12, ALU_SHL = 4'd13, ALU_SHR = 4'd14, ALU_NOT = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_ZERO  = 2'd0,
    IMM_EXT0  = 2'd1,
    IMM_EXT1  = 2'd2,
    IMM_SHAMT = 2'd3
  } imm_sel_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    alu_op_e          alu;
    logic             mem_rd;
    logic             mem_wr;
    imm_sel_e         imm_sel;
    logic             addr_ext0;
    logic             offs_en;
    logic             illegal;
  } dec_info_t;

endpackage

// File: rtl/dec_regchk.sv
module dec_regchk #(
  parameter int NUM_REGS = 6
) (
  input  logic [7:0] code,
  input  logic       used,
  output logic       bad
);
  // A used field must name one of the registers 1..NUM_REGS
  assign bad = used && ((code == 8'd0) || (code > 8'(NUM_REGS)));
endmodule

// File: rtl/dec_classify.sv
module dec_classify
  import dec_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic [31:0] word,
  output dec_info_t   info
);
  localparam int NFIELDS = 2;

  logic [7:0]         t;
  dec_info_t          base;
  logic               known;
  logic [NFIELDS-1:0] used;
  logic [NFIELDS-1:0] bad;

  assign t = word[7:0];

  always_comb begin
    base         = '0;
    base.alu     = ALU_NONE;
    base.imm_sel = IMM_ZERO;
    known        = 1'b1;
    used         = '0;
    unique case (t) inside
      8'h01: begin base.len = 2'd1; used[0] = 1'b1; base.imm_sel = IMM_EXT0; end
      8'h02: begin used = 2'b11; end
      8'h03: begin base.len = 2'd1; used[0] = 1'b1; base.addr_ext0 = 1'b1; base.mem_rd = 1'b1; end
      8'h04: begin used = 2'b11; base.mem_rd = 1'b1; end
      8'h05: begin
        base.len = 2'd2; base.addr_ext0 = 1'b1; base.imm_sel = IMM_EXT1; base.mem_wr = 1'b1;
      end
      8'h06: begin base.len = 2'd1; used[0] = 1'b1; base.imm_sel = IMM_EXT0; base.mem_wr = 1'b1; end
      8'h07: begin base.len = 2'd1; used[0] = 1'b1; base.addr_ext0 = 1'b1; base.mem_wr = 1'b1; end
      8'h08: begin used = 2'b11; base.mem_wr = 1'b1; end
      [8'h10:8'h16]: begin
        base.len = 2'd1; used[0] = 1'b1; base.imm_sel = IMM_EXT0;
        base.alu = alu_op_e'(t[3:0] + 4'd1);
      end
      8'h17: begin used[0] = 1'b1; base.alu = ALU_INC; end
      8'h18: begin used[0] = 1'b1; base.alu = ALU_DEC; end
      [8'h1A:8'h1C]: begin
        base.len = 2'd1; used[0] = 1'b1; base.imm_sel = IMM_EXT0;
        base.alu = alu_op_e'(t[3:0]);
      end
      8'h1D, 8'h1E: begin
        used[0] = 1'b1; base.imm_sel = IMM_SHAMT; base.alu = alu_op_e'(t[3:0]);
      end
      8'h1F: begin used[0] = 1'b1; base.alu = ALU_NOT; end
      [8'h20:8'h26]: begin used = 2'b11; base.alu = alu_op_e'(t[3:0] + 4'd1); end
      [8'h2A:8'h2E]: begin used = 2'b11; base.alu = alu_op_e'(t[3:0]); end
      [8'h50:8'h56]: begin base.offs_en = 1'b1; end
      8'h60: begin base.len = 2'd1; base.imm_sel = IMM_EXT0; base.mem_wr = 1'b1; end
      8'h61: begin used[0] = 1'b1; base.mem_wr = 1'b1; end
      8'h62: begin used[0] = 1'b1; base.mem_rd = 1'b1; end
      8'h70: begin base.offs_en = 1'b1; base.mem_wr = 1'b1; end
      8'h71: begin base.mem_rd = 1'b1; end
      8'h72: begin used[0] = 1'b1; base.mem_wr = 1'b1; end
      8'hEE, 8'hFF: begin end
      default: begin known = 1'b0; end
    endcase
  end

  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    dec_regchk #(.NUM_REGS(NUM_REGS)) u_chk (
      .code (word[8*g+15 -: 8]),
      .used (used[g]),
      .bad  (bad[g])
    );
  end

  always_comb begin
    info         = base;
    info.illegal = !known || (|bad);
  end

endmodule

// File: rtl/dec_collect.sv
module dec_collect #(
  parameter int MAX_EXT = 2,
  parameter int WORD_W  = 32,
  parameter int INFO_W  = 8,
  localparam int LEN_W  = $clog2(MAX_EXT + 1),
  localparam int IDX_W  = (MAX_EXT > 1) ? $clog2(MAX_EXT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WORD_W-1:0]         in_word,
  input  logic [LEN_W-1:0]          len_in,
  input  logic [INFO_W-1:0]         info_in,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W-1:0]         hdr_q,
  output logic [INFO_W-1:0]         info_q,
  output logic [MAX_EXT*WORD_W-1:0] ext_q
);
  logic             busy_q;
  logic             vld_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign in_ready  = !vld_q;
  assign out_valid = vld_q;
  assign take      = in_valid && !vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
      hdr_q  <= '0;
      info_q <= '0;
    end else begin
      if (vld_q && out_ready) vld_q <= 1'b0;
      if (take) begin
        if (!busy_q) begin
          hdr_q  <= in_word;
          info_q <= info_in;
          idx_q  <= '0;
          if (len_in == '0) begin
            vld_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            rem_q  <= len_in;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar k = 0; k < MAX_EXT; k++) begin : g_ext
    logic [WORD_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      r <= '0;
      else if (take && busy_q && idx_q == IDX_W'(k))   r <= in_word;
    end
    assign ext_q[k*WORD_W +: WORD_W] = r;
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import dec_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_type,
  output logic [7:0]  out_rega,
  output logic [7:0]  out_regb,
  output logic [1:0]  out_len,
  output logic [3:0]  out_alu,
  output logic        out_mem_rd,
  output logic        out_mem_wr,
  output logic [31:0] out_imm,
  output logic [31:0] out_addr,
  output logic [31:0] out_offset,
  output logic        out_illegal
);
  localparam int WORD_W = 32;
  localparam int INFO_W = $bits(dec_info_t);

  dec_info_t                 info_new;
  logic [INFO_W-1:0]         info_raw;
  dec_info_t                 info_q;
  logic [WORD_W-1:0]         hdr_q;
  logic [EXT_MAX*WORD_W-1:0] ext_q;
  logic [WORD_W-1:0]         ext0;
  logic [WORD_W-1:0]         ext1;

  dec_classify #(.NUM_REGS(NUM_REGS)) u_cls (
    .word (in_word),
    .info (info_new)
  );

  dec_collect #(
    .MAX_EXT (EXT_MAX),
    .WORD_W  (WORD_W),
    .INFO_W  (INFO_W)
  ) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .len_in    (info_new.len),
    .info_in   (info_new),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .hdr_q     (hdr_q),
    .info_q    (info_raw),
    .ext_q     (ext_q)
  );

  assign info_q = dec_info_t'(info_raw);
  assign ext0   = ext_q[0 +: WORD_W];
  assign ext1   = ext_q[WORD_W +: WORD_W];

  assign out_type    = hdr_q[7:0];
  assign out_rega    = hdr_q[15:8];
  assign out_regb    = hdr_q[23:16];
  assign out_len     = info_q.len;
  assign out_alu     = info_q.alu;
  assign out_mem_rd  = info_q.mem_rd;
  assign out_mem_wr  = info_q.mem_wr;
  assign out_illegal = info_q.illegal;
  assign out_addr    = info_q.addr_ext0 ? ext0 : '0;
  assign out_offset  = info_q.offs_en ? {{8{hdr_q[31]}}, hdr_q[31:8]} : '0;

  always_comb begin
    unique case (info_q.imm_sel)
      IMM_EXT0:  out_imm = ext0;
      IMM_EXT1:  out_imm = ext1;
      IMM_SHAMT: out_imm = {24'd0, hdr_q[23:16]};
      default:   out_imm = '0;
    endcase
  end

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_type,
  input logic [7:0]  out_regb,
  input logic [1:0]  out_len,
  input logic        out_mem_rd,
  input logic        out_mem_wr,
  input logic [31:0] out_imm,
  input logic [31:0] out_addr,
  input logic [31:0] out_offset
);
  logic [2:0] words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       words <= '0;
    else if (out_valid && out_ready)  words <= '0;
    else if (in_valid && in_ready)    words <= words + 3'd1;
  end

  assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_imm)
                                    && $stable(out_addr) && $stable(out_offset)));

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (words == {1'b0, out_len} + 3'd1));

  assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_offset != 32'd0) |-> (out_type inside {[8'h50:8'h56], 8'h70}));

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_mem_rd && out_mem_wr));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type == 8'h1D || out_type == 8'h1E)) |-> (out_imm == {24'd0, out_regb}));

endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_type   (out_type),
  .out_regb   (out_regb),
  .out_len    (out_len),
  .out_mem_rd (out_mem_rd),
  .out_mem_wr (out_mem_wr),
  .out_imm    (out_imm),
  .out_addr   (out_addr),
  .out_offset (out_offset)
);

// File: tb/instr_decoder_test.sv
`timescale 1ns/1ps
module instr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_type, out_rega, out_regb;
  logic [1:0]  out_len;
  logic [3:0]  out_alu;
  logic        out_mem_rd, out_mem_wr, out_illegal;
  logic [31:0] out_imm, out_addr, out_offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  instr_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_type(out_type), .out_rega(out_rega), .out_regb(out_regb),
    .out_len(out_len), .out_alu(out_alu), .out_mem_rd(out_mem_rd),
    .out_mem_wr(out_mem_wr), .out_imm(out_imm), .out_addr(out_addr),
    .out_offset(out_offset), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Present a header and n extension words, optionally with idle gaps.
  task automatic send(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                      input int n, input bit gap);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (gap && i > 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      if (i > 0) check("R3 record not ready before last word", out_valid, 1'b0);
      in_valid = 1'b1;
      in_word  = (i == 0) ? w0 : (i == 1) ? w1 : w2;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 record ready after last word", out_valid, 1'b1);
  endtask

  task automatic expect_rec(input logic [7:0] ty, input logic [7:0] ra, input logic [7:0] rb,
                            input logic [1:0] ln, input logic [3:0] al, input bit rd, input bit wr,
                            input logic [31:0] im, input logic [31:0] ad, input logic [31:0] of,
                            input bit il);
    check("R1 type", out_type, ty);
    check("R1 rega", out_rega, ra);
    check("R1 regb", out_regb, rb);
    check("R2 length", out_len, ln);
    check("R7 alu", out_alu, al);
    check("R8 mem_rd", out_mem_rd, rd);
    check("R8 mem_wr", out_mem_wr, wr);
    check("R5 imm", out_imm, im);
    check("R5 addr", out_addr, ad);
    check("R6 offset", out_offset, of);
    check("R9 R10 illegal", out_illegal, il);
  endtask

  task automatic release_out();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R4 valid cleared", out_valid, 1'b0);
    check("R4 ready restored", in_ready, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 valid in reset", out_valid, 1'b0);
    check("R11 ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 valid after reset", out_valid, 1'b0);
    check("R11 ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_moves();
    send(32'h0000_0401, 32'd42, 32'd0, 1, 1'b0);          // load D with 42
    expect_rec(8'h01, 8'h04, 8'h00, 2'd1, 4'd0, 0, 0, 32'd42, 32'd0, 32'd0, 0);
    release_out();
    send(32'h0000_0303, 32'h40, 32'd0, 1, 1'b0);           // load C from address 0x40
    expect_rec(8'h03, 8'h03, 8'h00, 2'd1, 4'd0, 1, 0, 32'd0, 32'h40, 32'd0, 0);
    release_out();
  endtask

  task automatic t_two_words_gap();
    send(32'h0000_0005, 32'h100, 32'hFFFF_FFFB, 2, 1'b1);  // store -5 at 0x100, with gaps
    expect_rec(8'h05, 8'h00, 8'h00, 2'd2, 4'd0, 0, 1, 32'hFFFF_FFFB, 32'h100, 32'd0, 0);
    release_out();
  endtask

  task automatic t_alu();
    send(32'h0003_0220, 32'd0, 32'd0, 0, 1'b0);            // add B,C
    expect_rec(8'h20, 8'h02, 8'h03, 2'd0, 4'd1, 0, 0, 32'd0, 32'd0, 32'd0, 0);
    release_out();
    send(32'h0000_0116, 32'd5, 32'd0, 1, 1'b0);            // compare A,5
    expect_rec(8'h16, 8'h01, 8'h00, 2'd1, 4'd7, 0, 0, 32'd5, 32'd0, 32'd0, 0);
    release_out();
    send(32'h0000_041A, 32'hF0, 32'd0, 1, 1'b0);           // and D,0xF0
    expect_rec(8'h1A, 8'h04, 8'h00, 2'd1, 4'd10, 0, 0, 32'hF0, 32'd0, 32'd0, 0);
    release_out();
    send(32'h0000_031F, 32'd0, 32'd0, 0, 1'b0);            // not C
    expect_rec(8'h1F, 8'h03, 8'h00, 2'd0, 4'd15, 0, 0, 32'd0, 32'd0, 32'd0, 0);
    release_out();
  endtask

  task automatic t_shift();
    send(32'h0020_011D, 32'd0, 32'd0, 0, 1'b0);            // shift A left by 32, no reg check on 23:16
    expect_rec(8'h1D, 8'h01, 8'h20, 2'd0, 4'd13, 0, 0, 32'h20, 32'd0, 32'd0, 0);
    release_out();
    send(32'h0003_022E, 32'd0, 32'd0, 0, 1'b0);            // shift B right by C
    expect_rec(8'h2E, 8'h02, 8'h03, 2'd0, 4'd14, 0, 0, 32'd0, 32'd0, 32'd0, 0);
    release_out();
  endtask

  task automatic t_branch();
    send(32'hFFFF_FD55, 32'd0, 32'd0, 0, 1'b0);            // jump if <= by -3
    expect_rec(8'h55, 8'hFD, 8'hFF, 2'd0, 4'd0, 0, 0, 32'd0, 32'd0, 32'hFFFF_FFFD, 0);
    release_out();
    send(32'h0000_0770, 32'd0, 32'd0, 0, 1'b0);            // call +7
    expect_rec(8'h70, 8'h07, 8'h00, 2'd0, 4'd0, 0, 1, 32'd0, 32'd0, 32'd7, 0);
    release_out();
  endtask

  task automatic t_stack();
    send(32'h0000_0262, 32'd0, 32'd0, 0, 1'b0);            // pop into B
    expect_rec(8'h62, 8'h02, 8'h00, 2'd0, 4'd0, 1, 0, 32'd0, 32'd0, 32'd0, 0);
    release_out();
  endtask

  task automatic t_illegal();
    send(32'h0000_0119, 32'd0, 32'd0, 0, 1'b0);            // undefined type 19
    check("R9 unknown type flagged", out_illegal, 1'b1);
    check("R2 unknown type length", out_len, 2'd0);
    release_out();
    send(32'h0000_0000, 32'd0, 32'd0, 0, 1'b0);            // type 00
    check("R9 type 00 flagged", out_illegal, 1'b1);
    release_out();
    send(32'h0000_0702, 32'd0, 32'd0, 0, 1'b0);            // move with codes 07 and 00
    check("R10 bad register codes", out_illegal, 1'b1);
    release_out();
    send(32'h0000_0010, 32'd9, 32'd0, 1, 1'b0);            // add-immediate with register 00
    check("R10 bad register still uses word", out_imm, 32'd9);
    check("R10 bad register flagged", out_illegal, 1'b1);
    release_out();
    send(32'h0000_00FF, 32'd0, 32'd0, 0, 1'b0);            // no-op decodes cleanly afterwards
    expect_rec(8'hFF, 8'h00, 8'h00, 2'd0, 4'd0, 0, 0, 32'd0, 32'd0, 32'd0, 0);
    release_out();
  endtask

  task automatic t_backpressure();
    send(32'h0000_0060, 32'h77, 32'd0, 1, 1'b0);           // push 0x77
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = 32'h0000_00FF;
      check("R4 ready low while held", in_ready, 1'b0);
      check("R4 valid held", out_valid, 1'b1);
      check("R4 type held", out_type, 8'h60);
      check("R5 push imm held", out_imm, 32'h77);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 push writes", out_mem_wr, 1'b1);
    release_out();
    send(32'h0000_0161, 32'd0, 32'd0, 0, 1'b0);            // push A
    expect_rec(8'h61, 8'h01, 8'h00, 2'd0, 4'd0, 0, 1, 32'd0, 32'd0, 32'd0, 0);
    release_out();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_moves();
    t_two_words_gap();
    t_alu();
    t_shift();
    t_branch();
    t_stack();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    report();
    $finish;
  end

endmodule